// File: doc/BRIEF.md
# Configurable-Sense External Interrupt Controller

This block watches eight external interrupt pins and turns activity on them into a single interrupt request for a processor. Every pin carries its own two-bit sense mode that selects what counts as activity: a low level, any edge, a falling edge or a rising edge. Pins are first brought into the clock domain by a short synchroniser chain. Edge modes then record an event in a sticky pending flag that software clears by writing a one to it. Low-level mode drives the request straight from the pin and records nothing.

Software works through a simple synchronous register bus. Writes take effect on the clock edge and reads are combinational. There are two sense-control bytes, a mask byte and a flag byte. A pin contributes to the combined request only when its mask bit and the global enable input are both set. When more than one source is requesting, the lowest pin number wins, and its index is shown with a valid bit. Software should change a pin's sense mode only while that pin is masked, then clear its flag before unmasking it, because a mode change can create a detection of its own.

Top module: `eint_ctrl`

## Requirements
- R1: After reset all four registers read 0x00, every pin is in low-level mode (code 2'b00), and irq_o and irq_valid_o are 0.
- R2: Sense code 2'b10 sets the pin's flag on a falling edge only, and code 2'b11 sets it on a rising edge only. The flag reads back three clock edges after the pin changes: two synchroniser stages, then the flag register.
- R3: Sense code 2'b01 sets the pin's flag on both a rising and a falling edge.
- R4: In low-level mode (2'b00) a pin requests for as long as its synchronised level is low, starting two clock edges after it goes low, and its flag never gets set.
- R5: A pin contributes to irq_o only when gie_i and its mask bit are both 1. With either one at 0, irq_o stays at 0 for that pin.
- R6: Edge flags are set whatever the state of the mask bit and gie_i.
- R7: Writing the flag register (address 0x3C) clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R8: When a pin's flag is set and cleared by a write in the same cycle, the flag ends up set.
- R9: irq_valid_o equals irq_o. When it is 1, irq_id_o holds the lowest-numbered pin that is requesting.
- R10: Register map. Address 0x6A is the sense byte for pins 7..4, with pin 7 at bits [7:6] and pin 4 at bits [1:0]. Address 0x69 is the sense byte for pins 3..0, with pin 3 at bits [7:6] and pin 0 at bits [1:0]. Address 0x3D is the mask and address 0x3C is the flags, with bit i belonging to pin i. Every register reads back what was written, except for the flag rules above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 8 | External interrupt pins, asynchronous |
| gie_i | input | 1 | Global interrupt enable from the processor |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data, combinational on the address |
| irq_o | output | 1 | Combined interrupt request |
| irq_id_o | output | 3 | Index of the highest-priority requesting pin |
| irq_valid_o | output | 1 | irq_id_o is meaningful |

## Verification
A wrong synchroniser depth or a wrong previous-sample register moves the flag away from the third clock edge after a pin change, or makes it miss the edge. A flag read at the exact cycle shows this at once. A flag that is set, cleared or kept wrongly appears on the flag byte of the bus as soon as the next read after the event. It appears on irq_o as soon as that pin is unmasked with gie_i high. Priority errors appear in irq_id_o as soon as two unmasked sources are pending together. Clearing them one at a time exposes the whole order.

// File: rtl/eint_pkg.sv
package eint_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
    parameter int NPIN   = 8,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pins_i,
    output logic [NPIN-1:0] sync_o
);

    logic [NPIN-1:0] stage_d [STAGES];
    logic [NPIN-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = pins_i;
        for (int k = 1; k < STAGES; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                stage_q[k] <= '1;
            end
        end else begin
            for (int k = 0; k < STAGES; k++) begin
                stage_q[k] <= stage_d[k];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/eint_sense.sv
module eint_sense
    import eint_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic [NPIN-1:0]   cur_i,
    input  logic [NPIN-1:0]   prev_i,
    input  logic [2*NPIN-1:0] sense_i,
    output logic [NPIN-1:0]   set_o,
    output logic [NPIN-1:0]   level_mode_o,
    output logic [NPIN-1:0]   level_req_o
);

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        sense_e mode;
        logic   rise;
        logic   fall;

        assign mode = sense_e'(sense_i[2*i+1 -: 2]);
        assign rise = cur_i[i] & ~prev_i[i];
        assign fall = ~cur_i[i] & prev_i[i];

        always_comb begin
            set_o[i]        = 1'b0;
            level_mode_o[i] = 1'b0;
            level_req_o[i]  = 1'b0;
            case (mode)
                SENSE_LOW: begin
                    level_mode_o[i] = 1'b1;
                    level_req_o[i]  = ~cur_i[i];
                end
                SENSE_ANY:  set_o[i] = rise | fall;
                SENSE_FALL: set_o[i] = fall;
                SENSE_RISE: set_o[i] = rise;
                default:    set_o[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/eint_regs.sv
module eint_regs #(
    parameter int               NPIN          = 8,
    parameter int               AW            = 8,
    parameter logic [AW-1:0]    ADDR_SENSE_LO = 8'h69,
    parameter logic [AW-1:0]    ADDR_SENSE_HI = 8'h6A,
    parameter logic [AW-1:0]    ADDR_MASK     = 8'h3D,
    parameter logic [AW-1:0]    ADDR_FLAG     = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [NPIN-1:0]   wdata_i,
    output logic [NPIN-1:0]   rdata_o,
    input  logic [NPIN-1:0]   sync_i,
    input  logic [NPIN-1:0]   set_i,
    output logic [2*NPIN-1:0] sense_o,
    output logic [NPIN-1:0]   mask_o,
    output logic [NPIN-1:0]   flag_o,
    output logic [NPIN-1:0]   prev_o
);

    typedef struct packed {
        logic [2*NPIN-1:0] sense;
        logic [NPIN-1:0]   mask;
        logic [NPIN-1:0]   flag;
        logic [NPIN-1:0]   prev;
    } regs_t;

    regs_t           st_d;
    regs_t           st_q;
    logic [NPIN-1:0] clr;

    always_comb begin
        st_d      = st_q;
        clr       = '0;
        st_d.prev = sync_i;
        if (we_i) begin
            if (addr_i == ADDR_SENSE_LO) st_d.sense[NPIN-1:0]      = wdata_i;
            if (addr_i == ADDR_SENSE_HI) st_d.sense[2*NPIN-1:NPIN] = wdata_i;
            if (addr_i == ADDR_MASK)     st_d.mask                 = wdata_i;
            if (addr_i == ADDR_FLAG)     clr                       = wdata_i;
        end
        // a new event overrides a clear in the same cycle
        st_d.flag = (st_q.flag & ~clr) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sense: '0, mask: '0, flag: '0, prev: '1};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_SENSE_LO) rdata_o = st_q.sense[NPIN-1:0];
        if (addr_i == ADDR_SENSE_HI) rdata_o = st_q.sense[2*NPIN-1:NPIN];
        if (addr_i == ADDR_MASK)     rdata_o = st_q.mask;
        if (addr_i == ADDR_FLAG)     rdata_o = st_q.flag;
    end

    assign sense_o = st_q.sense;
    assign mask_o  = st_q.mask;
    assign flag_o  = st_q.flag;
    assign prev_o  = st_q.prev;

endmodule

// File: rtl/eint_prio.sv
module eint_prio #(
    parameter int NPIN = 8,
    localparam int IW  = $clog2(NPIN)
) (
    input  logic [NPIN-1:0] req_i,
    output logic            valid_o,
    output logic [IW-1:0]   id_o
);

    always_comb begin
        valid_o = |req_i;
        id_o    = '0;
        for (int i = NPIN - 1; i >= 0; i--) begin
            if (req_i[i]) id_o = i[IW-1:0];
        end
    end

endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl #(
    parameter int            NPIN          = 8,
    parameter int            SYNC_STAGES   = 2,
    parameter int            AW            = 8,
    parameter logic [AW-1:0] ADDR_SENSE_LO = 8'h69,
    parameter logic [AW-1:0] ADDR_SENSE_HI = 8'h6A,
    parameter logic [AW-1:0] ADDR_MASK     = 8'h3D,
    parameter logic [AW-1:0] ADDR_FLAG     = 8'h3C,
    localparam int           IW            = $clog2(NPIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pins_i,
    input  logic            gie_i,
    input  logic            bus_we_i,
    input  logic [AW-1:0]   bus_addr_i,
    input  logic [NPIN-1:0] bus_wdata_i,
    output logic [NPIN-1:0] bus_rdata_o,
    output logic            irq_o,
    output logic [IW-1:0]   irq_id_o,
    output logic            irq_valid_o
);

    logic [NPIN-1:0]   sync_w;
    logic [NPIN-1:0]   prev_w;
    logic [NPIN-1:0]   set_w;
    logic [NPIN-1:0]   lvl_mode_w;
    logic [NPIN-1:0]   lvl_req_w;
    logic [2*NPIN-1:0] sense_w;
    logic [NPIN-1:0]   mask_w;
    logic [NPIN-1:0]   flag_w;
    logic [NPIN-1:0]   pend_w;
    logic [NPIN-1:0]   req_w;

    eint_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .sync_o (sync_w)
    );

    eint_sense #(.NPIN(NPIN)) u_sense (
        .cur_i        (sync_w),
        .prev_i       (prev_w),
        .sense_i      (sense_w),
        .set_o        (set_w),
        .level_mode_o (lvl_mode_w),
        .level_req_o  (lvl_req_w)
    );

    eint_regs #(
        .NPIN          (NPIN),
        .AW            (AW),
        .ADDR_SENSE_LO (ADDR_SENSE_LO),
        .ADDR_SENSE_HI (ADDR_SENSE_HI),
        .ADDR_MASK     (ADDR_MASK),
        .ADDR_FLAG     (ADDR_FLAG)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_we_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .rdata_o (bus_rdata_o),
        .sync_i  (sync_w),
        .set_i   (set_w),
        .sense_o (sense_w),
        .mask_o  (mask_w),
        .flag_o  (flag_w),
        .prev_o  (prev_w)
    );

    // level-mode pins follow the pin; edge-mode pins follow their flag
    assign pend_w = lvl_req_w | (flag_w & ~lvl_mode_w);
    assign req_w  = pend_w & mask_w & {NPIN{gie_i}};

    eint_prio #(.NPIN(NPIN)) u_prio (
        .req_i   (req_w),
        .valid_o (irq_valid_o),
        .id_o    (irq_id_o)
    );

    assign irq_o = |req_w;

endmodule

// File: rtl/eint_ctrl_chk.sv
module eint_ctrl_chk #(
    parameter int            NPIN      = 8,
    parameter int            AW        = 8,
    parameter logic [AW-1:0] ADDR_FLAG = 8'h3C,
    localparam int           IW        = $clog2(NPIN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gie_i,
    input logic              bus_we_i,
    input logic [AW-1:0]     bus_addr_i,
    input logic [NPIN-1:0]   bus_wdata_i,
    input logic              irq_o,
    input logic [IW-1:0]     irq_id_o,
    input logic              irq_valid_o,
    input logic [2*NPIN-1:0] sense_w,
    input logic [NPIN-1:0]   mask_w,
    input logic [NPIN-1:0]   flag_w,
    input logic [NPIN-1:0]   req_w
);

    a_r5_gie_gates_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |-> !irq_o);

    a_r9_valid_tracks_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o == irq_o);

    a_r9_id_is_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (req_w[irq_id_o] &&
                         ((req_w & ((NPIN'(1) << irq_id_o) - NPIN'(1))) == '0)));

    a_r5_id_is_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> mask_w[irq_id_o]);

    for (genvar i = 0; i < NPIN; i++) begin : g_bit
        a_r7_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_w[i]) |-> $past(bus_we_i && bus_addr_i == ADDR_FLAG && bus_wdata_i[i]));

        a_r4_no_flag_in_level: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_w[i]) |-> $past(sense_w[2*i+1 -: 2] != 2'b00));
    end

endmodule

bind eint_ctrl eint_ctrl_chk #(
    .NPIN      (NPIN),
    .AW        (AW),
    .ADDR_FLAG (ADDR_FLAG)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gie_i       (gie_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_o       (irq_o),
    .irq_id_o    (irq_id_o),
    .irq_valid_o (irq_valid_o),
    .sense_w     (sense_w),
    .mask_w      (mask_w),
    .flag_w      (flag_w),
    .req_w       (req_w)
);

// File: tb/eint_ctrl_tb.sv
`timescale 1ns/1ps
module eint_ctrl_tb;

    localparam logic [7:0] A_SLO  = 8'h69;
    localparam logic [7:0] A_SHI  = 8'h6A;
    localparam logic [7:0] A_MASK = 8'h3D;
    localparam logic [7:0] A_FLAG = 8'h3C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = 8'hFF;
    logic       gie = 1'b0;
    logic       we = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;
    logic [2:0] irq_id;
    logic       irq_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    eint_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pins_i      (pins),
        .gie_i       (gie),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .irq_id_o    (irq_id),
        .irq_valid_o (irq_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = 8'h00;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(A_SLO, v);  check("R1 sense lo", v, 8'h00);
        rd(A_SHI, v);  check("R1 sense hi", v, 8'h00);
        rd(A_MASK, v); check("R1 mask", v, 8'h00);
        rd(A_FLAG, v); check("R1 flags", v, 8'h00);
        check("R1 irq", irq, 1'b0);
        check("R1 valid", irq_valid, 1'b0);
    endtask

    task automatic t_regmap;
        logic [7:0] v;
        wr(A_SHI, 8'hE4);  rd(A_SHI, v);  check("R10 sense hi readback", v, 8'hE4);
        wr(A_SLO, 8'h1B);  rd(A_SLO, v);  check("R10 sense lo readback", v, 8'h1B);
        wr(A_MASK, 8'h5A); rd(A_MASK, v); check("R10 mask readback", v, 8'h5A);
        wr(A_MASK, 8'h00);
        wr(A_SLO, 8'hFF);
        rd(A_FLAG, v);     check("R10 flags untouched by config", v, 8'h00);
    endtask

    // hi = E4: pin7 rise, pin6 fall, pin5 any, pin4 low; mask and gie off
    task automatic t_edges;
        logic [7:0] v;
        pins[7:5] = 3'b000;
        cycles(2);
        rd(A_FLAG, v); check("R2 no flag before third edge", v, 8'h00);
        cycles(1);
        rd(A_FLAG, v); check("R2 R3 R6 falling flags with mask off", v, 8'h60);
        wr(A_FLAG, 8'h60);
        rd(A_FLAG, v); check("R7 w1c clears", v, 8'h00);
        pins[7:5] = 3'b111;
        cycles(3);
        rd(A_FLAG, v); check("R2 R3 rising flags", v, 8'hA0);
        wr(A_FLAG, 8'h00);
        rd(A_FLAG, v); check("R7 zero write no effect", v, 8'hA0);
        wr(A_FLAG, 8'hFF);
        rd(A_FLAG, v); check("R7 clear all", v, 8'h00);
    endtask

    task automatic t_level;
        logic [7:0] v;
        wr(A_MASK, 8'h10);
        gie = 1'b1;
        pins[4] = 1'b0;
        cycles(1);
        check("R4 not yet after one edge", irq, 1'b0);
        cycles(1);
        check("R4 level request", irq, 1'b1);
        check("R9 level id", irq_id, 3'd4);
        rd(A_FLAG, v); check("R4 no flag in level mode", v, 8'h00);
        gie = 1'b0; #1;
        check("R5 gie off blocks", irq, 1'b0);
        gie = 1'b1;
        wr(A_MASK, 8'h00); #1;
        check("R5 mask off blocks", irq, 1'b0);
        wr(A_MASK, 8'h10);
        pins[4] = 1'b1;
        cycles(2);
        check("R4 request drops with pin high", irq, 1'b0);
        rd(A_FLAG, v); check("R4 still no flag", v, 8'h00);
        gie = 1'b0;
        wr(A_MASK, 8'h00);
    endtask

    task automatic t_prio;
        logic [7:0] v;
        wr(A_SHI, 8'hFF);
        wr(A_SLO, 8'hFF);
        pins = 8'h00;
        cycles(3);
        rd(A_FLAG, v); check("R2 rise mode ignores falls", v, 8'h00);
        wr(A_MASK, 8'hFF);
        gie = 1'b1;
        pins[5] = 1'b1; pins[2] = 1'b1;
        cycles(3);
        check("R9 irq two pending", irq, 1'b1);
        check("R9 lowest id wins", irq_id, 3'd2);
        wr(A_FLAG, 8'h04);
        check("R9 next id", irq_id, 3'd5);
        check("R9 valid still", irq_valid, 1'b1);
        wr(A_FLAG, 8'h20);
        check("R9 none pending", irq_valid, 1'b0);
        check("R9 irq low", irq, 1'b0);
        gie = 1'b0;
    endtask

    task automatic t_set_wins;
        logic [7:0] v;
        pins[3] = 1'b1;
        cycles(3);
        rd(A_FLAG, v); check("R2 pin3 rise flag", v, 8'h08);
        pins[1] = 1'b1;
        cycles(2);
        wr(A_FLAG, 8'h0A);
        rd(A_FLAG, v); check("R8 set wins over clear, other bit cleared", v, 8'h02);
        wr(A_FLAG, 8'h02);
        rd(A_FLAG, v); check("R7 later clear works", v, 8'h00);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_regmap();
        t_edges();
        t_level();
        t_prio();
        t_set_wins();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule